// File: doc/BRIEF.md
# Codirectional 64 kbit/s Line Encoder

This block is the transmit half of a 64 kbit/s codirectional interface. It receives one PCM octet per frame as a short serial burst on the 2.048 Mbit/s system timing. The burst is qualified by a time-slot window. The block then sends the octets as a continuous dual-rail line signal. Each data bit becomes four line units, and each unit puts exactly one of the two rails high. Successive bits alternate in polarity. The polarity of the last bit of every octet is deliberately left unchanged, and the receiver uses this violation to find octet boundaries. An alarm input suppresses these violations.

The whole block runs on one system clock. Two strobes mark the data bits (`bit_stb`) and the 256 kHz line units (`unit_stb`). There is no fixed phase relation between the time-slot bursts and the line units. A two-octet elastic buffer sits between the capture side and the line side. When that buffer runs empty, the line repeats the previous octet and raises an insertion flag. When a new octet arrives while the buffer is full, that octet is discarded and a deletion flag is raised.

Top module: `codir_line_enc`

## Requirements
- R1: After reset, `line_pos`, `line_neg`, `slip_ins` and `slip_del` are low, and they stay low until the first `unit_stb`. The first `unit_stb` only fetches an octet. Line units start at the second strobe.
- R2: While `slot_act` is high, each `bit_stb` takes in `pcm_bit`, most significant bit first. An octet is complete after the eighth bit. Further strobes in the same window are ignored until `slot_act` goes low.
- R3: If `slot_act` falls before eight bits have been taken, the partial octet is discarded and nothing enters the buffer.
- R4: Every bit occupies four consecutive line units, and in each unit exactly one rail is high. With H meaning the bit's own polarity, a 0 is sent as H,L,H,L and a 1 is sent as H,H,L,L. For a positive bit, H drives `line_pos` and L drives `line_neg`. A negative bit swaps the two rails.
- R5: Each bit has the opposite polarity to the bit before it, with one exception: the last bit (LSB) of an octet keeps the polarity of the bit before it. The first bit after start-up is positive.
- R6: If `alarm_in` is high at the end of bit 6 of an octet, the last bit of that octet alternates like any other bit, so that octet carries no violation.
- R7: Octets leave the line in the order they were captured. The buffer holds up to two octets, and the next octet is fetched at the last unit of the current one.
- R8: If the buffer is empty at a fetch, the current octet is sent again. `slip_ins` is then high for exactly one unit period, beginning with the last unit of the octet being repeated.
- R9: An octet completed while two are already held is dropped. `slip_del` is then high for exactly one unit period, beginning at the next `unit_stb`.
- R10: Line rails and slip flags change only at a clock edge where `unit_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe per 2.048 Mbit/s input bit |
| slot_act | input | 1 | Transmit time-slot window |
| pcm_bit | input | 1 | Serial PCM data, MSB first |
| unit_stb | input | 1 | One-cycle strobe per 256 kHz line unit |
| alarm_in | input | 1 | When high, suppresses octet-timing violations |
| line_pos | output | 1 | Positive rail of the line signal |
| line_neg | output | 1 | Negative rail of the line signal |
| slip_ins | output | 1 | Octet repeated because the buffer ran empty |
| slip_del | output | 1 | Octet dropped because the buffer was full |

## Verification
The bench sends three octets while the line is stopped. The third has to be dropped, and the deletion flag must show up only once the line starts. A design that writes over a held octet would put the wrong data on the line, and one that signals the flag early would break R10. An aborted time slot and deliberately skipped frames force underflows. A design that sends stale buffer contents instead of repeating the last octet, or that holds the insertion flag for longer than one unit, is caught by the line decoder. An over-long time slot checks that bits after the eighth are ignored. Toggling the alarm octet by octet checks that the violation disappears only when the alarm is high, and that every other bit keeps alternating.

// File: rtl/codir_pkg.sv
package codir_pkg;

    typedef enum logic [1:0] {
        CAP_WAIT,
        CAP_SHIFT,
        CAP_HOLD
    } cap_state_t;

    typedef enum logic {
        TX_IDLE,
        TX_RUN
    } tx_state_t;

    localparam int UNITS_PER_BIT = 4;

    // Level of one line unit relative to the bit's own polarity (1 = mark).
    function automatic logic unit_level(input logic b, input logic [1:0] u);
        return b ? ~u[1] : ~u[0];
    endfunction

endpackage

// File: rtl/codir_capture.sv
module codir_capture
    import codir_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              slot_act,
    input  logic              pcm_bit,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_dat
);
    localparam int CW = $clog2(BYTE_W);

    cap_state_t        state, state_nx;
    logic [CW-1:0]     cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] sh_nx;
    logic              take;
    logic              last;

    assign sh_nx = {sh[BYTE_W-2:0], pcm_bit};
    assign take  = bit_stb && slot_act && (state != CAP_HOLD);
    assign last  = (cnt == CW'(BYTE_W-1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAP_WAIT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CAP_WAIT:  if (take) state_nx = CAP_SHIFT;
            CAP_SHIFT: begin
                if (!slot_act)         state_nx = CAP_WAIT;
                else if (take && last) state_nx = CAP_HOLD;
            end
            CAP_HOLD:  if (!slot_act) state_nx = CAP_WAIT;
            default:   state_nx = CAP_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            sh       <= '0;
            byte_vld <= 1'b0;
            byte_dat <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (take) begin
                sh <= sh_nx;
                if (state == CAP_WAIT) begin
                    cnt <= CW'(1);
                end else begin
                    cnt <= cnt + CW'(1);
                    if (last) begin
                        byte_vld <= 1'b1;
                        byte_dat <= sh_nx;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/codir_bytebuf.sv
module codir_bytebuf #(
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              pop,
    output logic [BYTE_W-1:0] rdata,
    output logic              empty,
    output logic              drop
);
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNW = $clog2(DEPTH + 1);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic [CNW-1:0]    cnt;
    logic              full;
    logic              wr_ok;

    assign full  = (cnt == CNW'(DEPTH));
    assign empty = (cnt == '0);
    assign wr_ok = push && (!full || pop);
    assign drop  = push && full && !pop;
    assign rdata = mem[rp];

    function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        mem[i] <= '0;
            else if (wr_ok && wp == AW'(i))    mem[i] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_ok) wp <= inc(wp);
            if (pop)   rp <= inc(rp);
            if (wr_ok && !pop)      cnt <= cnt + CNW'(1);
            else if (pop && !wr_ok) cnt <= cnt - CNW'(1);
        end
    end
endmodule

// File: rtl/codir_serializer.sv
module codir_serializer
    import codir_pkg::*;
#(
    parameter int                BYTE_W    = 8,
    parameter logic [BYTE_W-1:0] HOLD_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unit_stb,
    input  logic              alarm_in,
    input  logic              buf_empty,
    input  logic [BYTE_W-1:0] buf_rdata,
    input  logic              drop_evt,
    output logic              buf_pop,
    output logic              line_pos,
    output logic              line_neg,
    output logic              slip_ins,
    output logic              slip_del
);
    localparam int IW = $clog2(BYTE_W);
    localparam int UW = $clog2(UNITS_PER_BIT);
    localparam logic [IW-1:0] LAST_BIT = IW'(BYTE_W-1);
    localparam logic [UW-1:0] LAST_UNIT = UW'(UNITS_PER_BIT-1);

    tx_state_t         state, state_nx;
    logic [BYTE_W-1:0] cur;
    logic [IW-1:0]     bitn;
    logic [UW-1:0]     unit;
    logic              pol;
    logic              del_pend;
    logic              at_end;
    logic              fetch;
    logic              cur_bit;
    logic              lvl;

    assign at_end  = (unit == LAST_UNIT) && (bitn == LAST_BIT);
    assign fetch   = unit_stb && ((state == TX_IDLE) || at_end);
    assign buf_pop = fetch && !buf_empty;
    assign cur_bit = cur[LAST_BIT - bitn];
    assign lvl     = unit_level(cur_bit, unit[1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE: if (unit_stb) state_nx = TX_RUN;
            TX_RUN:  state_nx = TX_RUN;
            default: state_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur      <= HOLD_INIT;
            bitn     <= '0;
            unit     <= '0;
            pol      <= 1'b1;
            del_pend <= 1'b0;
            line_pos <= 1'b0;
            line_neg <= 1'b0;
            slip_ins <= 1'b0;
            slip_del <= 1'b0;
        end else if (unit_stb) begin
            slip_ins <= fetch && buf_empty;
            slip_del <= del_pend || drop_evt;
            del_pend <= 1'b0;
            if (buf_pop) cur <= buf_rdata;
            unique case (state)
                TX_IDLE: begin
                    bitn <= '0;
                    unit <= '0;
                    pol  <= 1'b1;
                end
                TX_RUN: begin
                    line_pos <= (lvl == pol);
                    line_neg <= (lvl != pol);
                    if (unit == LAST_UNIT) begin
                        unit <= '0;
                        if (bitn == LAST_BIT) begin
                            bitn <= '0;
                            pol  <= ~pol;
                        end else begin
                            bitn <= bitn + IW'(1);
                            if (!((bitn == LAST_BIT - IW'(1)) && !alarm_in))
                                pol <= ~pol;
                        end
                    end else begin
                        unit <= unit + UW'(1);
                    end
                end
                default: ;
            endcase
        end else begin
            del_pend <= del_pend || drop_evt;
        end
    end
endmodule

// File: rtl/codir_line_enc.sv
module codir_line_enc
    import codir_pkg::*;
#(
    parameter int                BYTE_W    = 8,
    parameter int                BUF_DEPTH = 2,
    parameter logic [BYTE_W-1:0] HOLD_INIT = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic slot_act,
    input  logic pcm_bit,
    input  logic unit_stb,
    input  logic alarm_in,
    output logic line_pos,
    output logic line_neg,
    output logic slip_ins,
    output logic slip_del
);
    logic              cap_vld;
    logic [BYTE_W-1:0] cap_dat;
    logic              buf_pop;
    logic              buf_empty;
    logic              buf_drop;
    logic [BYTE_W-1:0] buf_rdata;

    codir_capture #(.BYTE_W(BYTE_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .slot_act (slot_act),
        .pcm_bit  (pcm_bit),
        .byte_vld (cap_vld),
        .byte_dat (cap_dat)
    );

    codir_bytebuf #(.BYTE_W(BYTE_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cap_vld),
        .wdata (cap_dat),
        .pop   (buf_pop),
        .rdata (buf_rdata),
        .empty (buf_empty),
        .drop  (buf_drop)
    );

    codir_serializer #(.BYTE_W(BYTE_W), .HOLD_INIT(HOLD_INIT)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .unit_stb  (unit_stb),
        .alarm_in  (alarm_in),
        .buf_empty (buf_empty),
        .buf_rdata (buf_rdata),
        .drop_evt  (buf_drop),
        .buf_pop   (buf_pop),
        .line_pos  (line_pos),
        .line_neg  (line_neg),
        .slip_ins  (slip_ins),
        .slip_del  (slip_del)
    );
endmodule

// File: rtl/codir_line_enc_chk.sv
module codir_line_enc_chk (
    input logic clk,
    input logic rst_n,
    input logic unit_stb,
    input logic line_pos,
    input logic line_neg,
    input logic slip_ins,
    input logic slip_del,
    input logic buf_pop,
    input logic buf_empty
);
    p_rails_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({line_pos, line_neg}));

    p_line_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_stb |=> ($stable(line_pos) && $stable(line_neg)));

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_stb |=> ($stable(slip_ins) && $stable(slip_del)));

    p_ins_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_stb && slip_ins) |=> !slip_ins);

    p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_pop |-> !buf_empty);
endmodule

bind codir_line_enc codir_line_enc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .unit_stb  (unit_stb),
    .line_pos  (line_pos),
    .line_neg  (line_neg),
    .slip_ins  (slip_ins),
    .slip_del  (slip_del),
    .buf_pop   (buf_pop),
    .buf_empty (buf_empty)
);

// File: tb/sim_codir_line_enc.sv
`timescale 1ns/1ps
module sim_codir_line_enc;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0, slot_act = 1'b0, pcm_bit = 1'b0;
    logic unit_stb = 1'b0, alarm_in = 1'b0;
    logic line_pos, line_neg, slip_ins, slip_del;

    always #4 clk = ~clk;

    codir_line_enc u0 (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .slot_act(slot_act),
        .pcm_bit(pcm_bit), .unit_stb(unit_stb), .alarm_in(alarm_in),
        .line_pos(line_pos), .line_neg(line_neg),
        .slip_ins(slip_ins), .slip_del(slip_del)
    );

    int total = 0, bad = 0;
    bit done = 1'b0;
    logic [7:0] q[$];
    int del_exp = 0, del_seen = 0, ins_seen = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    // unit strobe: one cycle in eight while running
    bit run = 1'b0;
    int ucnt = 0;
    always @(negedge clk) begin
        if (!run) begin
            ucnt = 0;
            unit_stb = 1'b0;
        end else begin
            unit_stb = (ucnt == 0);
            ucnt = (ucnt == 7) ? 0 : ucnt + 1;
        end
    end

    logic uen_q = 1'b0;
    always @(posedge clk) uen_q <= unit_stb;

    // driver
    task automatic send_burst(input logic [7:0] b, input int nbits, input bit keep);
        @(negedge clk) slot_act = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            pcm_bit = (i < 8) ? b[7-i] : ~b[0];
            bit_stb = 1'b1;
            @(negedge clk) bit_stb = 1'b0;
            repeat (2) @(negedge clk);
        end
        @(negedge clk) slot_act = 1'b0;
        repeat (2) @(negedge clk);
        if (keep) q.push_back(b);
    endtask

    // monitor / scoreboard
    int n = 0, oct_start = 0, oct_done = 0;
    logic [7:0] exp_oct = 8'hFF, last_oct = 8'hFF, got = 8'h00;
    logic up [4];
    logic un [4];
    logic prev_pol = 1'b0, alm_b6 = 1'b0, prev_ins = 1'b0;
    bit first_bit = 1'b1, code_ok = 1'b1, pol_ok = 1'b1;

    task automatic do_fetch();
        if (slip_ins) begin
            ins_seen++;
            chk(q.size() == 0, "R8 repeat only when empty", q.size(), 0);
            exp_oct = last_oct;
        end else begin
            chk(q.size() != 0, "R8 missing insertion flag", 0, 1);
            if (q.size() != 0) exp_oct = q.pop_front();
        end
    endtask

    always @(negedge clk) begin
        if (uen_q) begin
            if (prev_ins) chk(!slip_ins, "R8 flag width", slip_ins, 0);
            prev_ins = slip_ins;
            if (slip_del) del_seen++;
            if (n == 0) begin
                chk(!line_pos && !line_neg, "R1 no unit at fetch", {line_pos, line_neg}, 0);
                chk(slip_del, "R9 deletion flag at first strobe", slip_del, 1);
                do_fetch();
            end else begin
                int pos, bn, u;
                pos = (n - 1) % 32;
                bn = pos / 4;
                u = pos % 4;
                if (pos == 0) begin
                    got = 8'h00;
                    code_ok = 1'b1;
                    pol_ok = 1'b1;
                    oct_start++;
                end
                up[u] = line_pos;
                un[u] = line_neg;
                if (u == 3) begin
                    logic s, b;
                    s = up[0];
                    b = (up[1] == up[0]);
                    for (int k = 0; k < 4; k++)
                        if (up[k] == un[k]) code_ok = 1'b0;
                    if (up[2] == up[1] || up[3] == up[0]) code_ok = 1'b0;
                    if (first_bit) begin
                        if (s != 1'b1) pol_ok = 1'b0;
                        first_bit = 1'b0;
                    end else if (bn == 7) begin
                        if (alm_b6 ? (s == prev_pol) : (s != prev_pol)) pol_ok = 1'b0;
                    end else begin
                        if (s == prev_pol) pol_ok = 1'b0;
                    end
                    prev_pol = s;
                    got = {got[6:0], b};
                    if (bn == 6) alm_b6 = alarm_in;
                end
                if (pos == 31) begin
                    chk(code_ok, "R4 unit coding", code_ok, 1);
                    if (alm_b6) chk(pol_ok, "R6 alarm removes violation", pol_ok, 1);
                    else        chk(pol_ok, "R5 alternation and violation", pol_ok, 1);
                    chk(got == exp_oct, "R7 octet data/order (R2 capture)", got, exp_oct);
                    last_oct = got;
                    oct_done++;
                    do_fetch();
                end
            end
            n++;
        end
    end

    task automatic at_octet(input int k);
        wait (oct_start == k + 1);
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!line_pos && !line_neg, "R1 rails after reset", {line_pos, line_neg}, 0);
        chk(!slip_ins && !slip_del, "R1 flags after reset", {slip_ins, slip_del}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        send_burst(8'hA9, 8, 1'b1);
        send_burst(8'h01, 12, 1'b1);   // R2: extra strobes ignored
        send_burst(8'h80, 8, 1'b0);    // R9: dropped, buffer full
        del_exp++;
        repeat (5) @(negedge clk);
        chk(!slip_del, "R10 deletion flag waits for unit strobe", slip_del, 0);
        chk(!line_pos && !line_neg, "R1 quiet before strobes", {line_pos, line_neg}, 0);
        run = 1'b1;
        at_octet(1);
        send_burst(8'h5C, 5, 1'b0);    // R3: aborted burst
        at_octet(2);
        send_burst(8'h10, 8, 1'b1);
        at_octet(3);
        alarm_in = 1'b1;
        send_burst(8'h5A, 8, 1'b1);
        at_octet(4);
        alarm_in = 1'b0;
        send_burst(8'h3C, 8, 1'b1);
        send_burst(8'hC3, 8, 1'b1);
        send_burst(8'h77, 8, 1'b0);    // R9: overflow while running
        del_exp++;
        at_octet(7);
        send_burst(8'h00, 8, 1'b1);
        at_octet(8);
        alarm_in = 1'b1;
        send_burst(8'hFF, 8, 1'b1);
        at_octet(9);
        alarm_in = 1'b0;
        send_burst(8'h81, 8, 1'b1);
        wait (oct_done >= 11);
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R7 all kept octets sent", q.size(), 0);
        chk(del_seen == del_exp, "R9 deletion pulse count", del_seen, del_exp);
        chk(ins_seen == 3, "R8 insertion pulse count (R3 abort adds none)", ins_seen, 3);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", oct_done, 11);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule